// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches up to eight asynchronous interrupt pins and turns their activity into interrupt requests for the rest of the chip. Each pin is first passed through a two-flop synchroniser. A per-pin sense setting then decides whether the pin raises a request on a falling edge, a rising edge, either edge, a low level or a high level. Detected events are held in a pending register. A pending event reaches its output only when the pin is unmasked and its priority field is nonzero. A combined output ORs all pin outputs together.

Software reaches the block through a plain register port: address, write enable, write data and read data. Read data is combinational from the address. Pending bits are cleared by writing zeros. Masking uses two write-only registers, one that sets mask bits and one that clears them, so no read-modify-write is needed. A one-bit mode select is stored and can be read back for the surrounding logic.

Top module: `xpin_ctrl`

## Requirements
- R1: Each pin goes through two synchronising flops and then an event detector. When a pin changes just before clock edge k, the resulting pending bit and output appear after edge k+2.
- R2: The sense register is at address 0 and holds 32 bits, all readable and writable. Pin n's field is W bits wide (W = 4 by default) and its least significant bit is at 32 − (n+1)·W, so pin 0 has the top field.
- R3: The sense codes are 0 for falling edge, 1 for rising edge, 2 for low level, 3 for high level and 4 for both edges. Any other code produces no events.
- R4: In a level mode, pending is set on every cycle that the synchronised pin is at its active level. If a detected event and a software clear hit the same pending bit in the same cycle, the bit is set.
- R5: The pending register is at address 2, and pin n is at bit 7 − n. Reading returns the pending bits in bits 7:0, and bits 31:8 read as 0. On a write, each bit written as 0 is cleared and each bit written as 1 keeps its value.
- R6: The mask-set register is at address 3 and is write-only. Writing 1 at bit 7 − n masks pin n, and 0 bits leave the mask unchanged. It reads as 0. A masked pin still records pending events.
- R7: The mask-clear register is at address 4 and is write-only. Writing 1 at bit 7 − n unmasks pin n, and 0 bits leave the mask unchanged. It reads as 0.
- R8: The priority register is at address 1 and holds 32 bits, with pin n's 4-bit field at bits 28 − 4n +: 4. irq_o[n] = pending[n] & ~mask[n] & (field ≠ 0), and irq_any_o is the OR of all irq_o bits.
- R9: The mode register is at address 5 and stores only bit 23. All other bits read as 0. Addresses 6 and 7 read as 0.
- R10: A synchronous reset clears the sense, priority, pending and mode registers and the synchronisers, and masks every pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_PINS | Asynchronous interrupt pins, bit n = pin n |
| bus_we_i | input | 1 | Register write enable |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | NUM_PINS | Per-pin interrupt request |
| irq_any_o | output | 1 | OR of all pin requests |

## Verification
The hardest case to reach is a pin held at its active level while software writes zeros to the pending register in the same cycle. The set must win, and the bit must not drop for even one cycle. The directed part of the bench holds a pin high in high-level mode and issues back-to-back clearing writes, reading the pending register between them. The random part mixes pin toggles, sense changes and pending writes so that edge events also land on cycles that carry a clear.

// File: rtl/xpin_pkg.sv
package xpin_pkg;

    localparam int REG_W     = 32;
    localparam int ADDR_W    = 3;
    localparam int MAP_W     = 8;
    localparam int PRIO_W    = 4;
    localparam int MODE_BIT  = 23;

    typedef enum logic [ADDR_W-1:0] {
        A_SENSE = 3'd0,
        A_PRIO  = 3'd1,
        A_PEND  = 3'd2,
        A_MSET  = 3'd3,
        A_MCLR  = 3'd4,
        A_MODE  = 3'd5
    } reg_addr_e;

    typedef enum logic [3:0] {
        SN_FALL = 4'd0,
        SN_RISE = 4'd1,
        SN_LOW  = 4'd2,
        SN_HIGH = 4'd3,
        SN_BOTH = 4'd4
    } sense_e;

    typedef struct packed {
        logic                  we;
        reg_addr_e             addr;
        logic [REG_W-1:0]      wdata;
    } bus_req_t;

    // Low bit of pin n's field in an MSB-first packed register.
    function automatic int field_lsb(input int pin, input int width);
        return REG_W - (pin + 1) * width;
    endfunction

    // Bit of pin n in the 8-bit pending/mask layout.
    function automatic int map_pos(input int pin);
        return MAP_W - 1 - pin;
    endfunction

    // Bits of the 8-bit layout that belong to implemented pins.
    function automatic logic [MAP_W-1:0] valid_map(input int pins);
        logic [MAP_W-1:0] v;
        v = '0;
        for (int k = 0; k < pins; k++) v[map_pos(k)] = 1'b1;
        return v;
    endfunction

    function automatic logic sense_hit(input logic [3:0] code, input logic cur, input logic prv);
        case (sense_e'(code))
            SN_FALL: return prv & ~cur;
            SN_RISE: return ~prv & cur;
            SN_LOW:  return ~cur;
            SN_HIGH: return cur;
            SN_BOTH: return prv ^ cur;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/xpin_sync.sv
module xpin_sync #(
    parameter int NUM_PINS = 8,
    parameter int STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic [NUM_PINS-1:0] sync_o
);
    logic [NUM_PINS-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= pin_i;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[k] <= '0;
            else     stg[k] <= stg[k-1];
        end
    end

    assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/xpin_detect.sv
module xpin_detect
    import xpin_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int SENSE_W  = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] sync_i,
    input  logic [REG_W-1:0]    sense_i,
    output logic [NUM_PINS-1:0] ev_o
);
    logic [NUM_PINS-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= sync_i;
    end

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        localparam int LSB = field_lsb(g, SENSE_W);
        logic [3:0] code;
        assign code  = 4'(sense_i[LSB +: SENSE_W]);
        assign ev_o[g] = sense_hit(code, sync_i[g], prev_q[g]);
    end
endmodule

// File: rtl/xpin_regs.sv
module xpin_regs
    import xpin_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  bus_req_t            req_i,
    input  logic [NUM_PINS-1:0] ev_i,
    output logic [REG_W-1:0]    rdata_o,
    output logic [REG_W-1:0]    sense_o,
    output logic [REG_W-1:0]    prio_o,
    output logic [NUM_PINS-1:0] pend_o,
    output logic [NUM_PINS-1:0] mask_o,
    output logic                mode_o
);
    localparam logic [MAP_W-1:0] VALID = valid_map(NUM_PINS);

    logic [REG_W-1:0] sense_q, prio_q;
    logic [MAP_W-1:0] pend_q, mask_q, pend_d, ev_map;
    logic             mode_q;
    logic             wr_sense, wr_prio, wr_pend, wr_mset, wr_mclr, wr_mode;

    for (genvar g = 0; g < MAP_W; g++) begin : g_map
        if (g < NUM_PINS) begin : g_on
            assign ev_map[map_pos(g)] = ev_i[g];
            assign pend_o[g]          = pend_q[map_pos(g)];
            assign mask_o[g]          = mask_q[map_pos(g)];
        end else begin : g_off
            assign ev_map[map_pos(g)] = 1'b0;
        end
    end

    assign wr_sense = req_i.we && (req_i.addr == A_SENSE);
    assign wr_prio  = req_i.we && (req_i.addr == A_PRIO);
    assign wr_pend  = req_i.we && (req_i.addr == A_PEND);
    assign wr_mset  = req_i.we && (req_i.addr == A_MSET);
    assign wr_mclr  = req_i.we && (req_i.addr == A_MCLR);
    assign wr_mode  = req_i.we && (req_i.addr == A_MODE);

    always_comb begin
        pend_d = pend_q;
        if (wr_pend) pend_d = pend_q & req_i.wdata[MAP_W-1:0];
        pend_d = (pend_d | ev_map) & VALID;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sense_q <= '0;
            prio_q  <= '0;
            pend_q  <= '0;
            mask_q  <= VALID;
            mode_q  <= 1'b0;
        end else begin
            pend_q <= pend_d;
            if (wr_sense) sense_q <= req_i.wdata;
            if (wr_prio)  prio_q  <= req_i.wdata;
            if (wr_mset)  mask_q  <= mask_q | (req_i.wdata[MAP_W-1:0] & VALID);
            if (wr_mclr)  mask_q  <= mask_q & ~req_i.wdata[MAP_W-1:0];
            if (wr_mode)  mode_q  <= req_i.wdata[MODE_BIT];
        end
    end

    always_comb begin
        rdata_o = '0;
        case (req_i.addr)
            A_SENSE: rdata_o = sense_q;
            A_PRIO:  rdata_o = prio_q;
            A_PEND:  rdata_o[MAP_W-1:0] = pend_q;
            A_MODE:  rdata_o[MODE_BIT] = mode_q;
            default: rdata_o = '0;
        endcase
    end

    assign sense_o = sense_q;
    assign prio_o  = prio_q;
    assign mode_o  = mode_q;

    // R4: a detected event always leaves its pending bit set
    p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
        (|ev_map) |=> ((pend_q & $past(ev_map)) == $past(ev_map)));

    // R5: zeros written to pending clear, ones keep
    p_zero_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_pend && ev_map == '0) |=> (pend_q == $past(pend_q & req_i.wdata[MAP_W-1:0])));

    // R6: ones written to mask-set mask the pin
    p_mask_set_r6: assert property (@(posedge clk) disable iff (rst)
        wr_mset |=> ((mask_q & $past(req_i.wdata[MAP_W-1:0] & VALID))
                     == $past(req_i.wdata[MAP_W-1:0] & VALID)));

    // R7: ones written to mask-clear unmask the pin
    p_mask_clr_r7: assert property (@(posedge clk) disable iff (rst)
        wr_mclr |=> ((mask_q & $past(req_i.wdata[MAP_W-1:0])) == '0));

    // R9: mode register exposes only its select bit
    p_mode_only_r9: assert property (@(posedge clk) disable iff (rst)
        (req_i.addr == A_MODE) |-> ((rdata_o & ~(32'd1 << MODE_BIT)) == '0));
endmodule

// File: rtl/xpin_ctrl.sv
module xpin_ctrl
    import xpin_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int SENSE_W  = 4,
    parameter int STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                bus_we_i,
    input  logic [2:0]          bus_addr_i,
    input  logic [31:0]         bus_wdata_i,
    output logic [31:0]         bus_rdata_o,
    output logic [NUM_PINS-1:0] irq_o,
    output logic                irq_any_o
);
    bus_req_t            req;
    logic [NUM_PINS-1:0] sync, ev, pend, mask;
    logic [REG_W-1:0]    sense, prio;
    logic                mode;

    assign req.we    = bus_we_i;
    assign req.addr  = reg_addr_e'(bus_addr_i);
    assign req.wdata = bus_wdata_i;

    xpin_sync #(.NUM_PINS(NUM_PINS), .STAGES(STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin_i(pin_i), .sync_o(sync)
    );

    xpin_detect #(.NUM_PINS(NUM_PINS), .SENSE_W(SENSE_W)) u_detect (
        .clk(clk), .rst(rst), .sync_i(sync), .sense_i(sense), .ev_o(ev)
    );

    xpin_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk(clk), .rst(rst), .req_i(req), .ev_i(ev),
        .rdata_o(bus_rdata_o), .sense_o(sense), .prio_o(prio),
        .pend_o(pend), .mask_o(mask), .mode_o(mode)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_gate
        localparam int PLSB = field_lsb(g, PRIO_W);
        assign irq_o[g] = pend[g] & ~mask[g] & (prio[PLSB +: PRIO_W] != '0);
    end

    assign irq_any_o = |irq_o;

    // R8: the combined request needs an unmasked pending pin
    p_any_r8: assert property (@(posedge clk) disable iff (rst)
        irq_any_o |-> (|(pend & ~mask)));

    // R10: right after reset nothing is requested and the mode bit is clear
    p_reset_r10: assert property (@(posedge clk)
        rst |=> (irq_o == '0 && !mode));
endmodule

// File: tb/xpin_ctrl_tb.sv
`timescale 1ns/100ps
module xpin_ctrl_tb;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [N-1:0] pins = '0;
    logic        bwe = 1'b0;
    logic [2:0]  baddr = '0;
    logic [31:0] bwd = '0;
    logic [31:0] rdata;
    logic [N-1:0] irq;
    logic        irq_any;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    xpin_ctrl u_dut (
        .clk(clk), .rst(rst), .pin_i(pins), .bus_we_i(bwe),
        .bus_addr_i(baddr), .bus_wdata_i(bwd), .bus_rdata_o(rdata),
        .irq_o(irq), .irq_any_o(irq_any)
    );

    // Reference state, built from the requirements
    logic [7:0]  ms1, ms2, mprev, mpend, mmask;
    logic [31:0] msense, mprio;
    logic        mmode;

    function automatic logic ref_hit(input logic [3:0] c, input logic cur, input logic prv);
        if (c == 4'd0) return prv && !cur;
        if (c == 4'd1) return !prv && cur;
        if (c == 4'd2) return !cur;
        if (c == 4'd3) return cur;
        if (c == 4'd4) return prv != cur;
        return 1'b0;
    endfunction

    function automatic logic [7:0] ref_events();
        logic [7:0] e = '0;
        for (int n = 0; n < N; n++)
            e[7-n] = ref_hit(msense[28-4*n +: 4], ms2[n], mprev[n]);
        return e;
    endfunction

    function automatic logic [N-1:0] ref_irq();
        logic [N-1:0] r;
        for (int n = 0; n < N; n++)
            r[n] = mpend[7-n] && !mmask[7-n] && (mprio[28-4*n +: 4] != 4'd0);
        return r;
    endfunction

    function automatic logic [31:0] ref_rd(input logic [2:0] a);
        case (a)
            3'd0: return msense;
            3'd1: return mprio;
            3'd2: return {24'd0, mpend};
            3'd5: return {8'd0, mmode, 23'd0};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            ms1 <= '0; ms2 <= '0; mprev <= '0; mpend <= '0; mmask <= 8'hFF;
            msense <= '0; mprio <= '0; mmode <= 1'b0;
        end else begin
            ms1 <= pins; ms2 <= ms1; mprev <= ms2;
            mpend <= ((bwe && baddr == 3'd2) ? (mpend & bwd[7:0]) : mpend) | ref_events();
            if (bwe && baddr == 3'd0) msense <= bwd;
            if (bwe && baddr == 3'd1) mprio  <= bwd;
            if (bwe && baddr == 3'd3) mmask  <= mmask | bwd[7:0];
            if (bwe && baddr == 3'd4) mmask  <= mmask & ~bwd[7:0];
            if (bwe && baddr == 3'd5) mmode  <= bwd[23];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, then compare all outputs
    task automatic cyc(input logic we, input logic [2:0] a, input logic [31:0] d, input string tag);
        @(negedge clk);
        bwe = we; baddr = a; bwd = d;
        #1;
        chk({tag, " irq"}, 32'(irq), 32'(ref_irq()));
        chk({tag, " any"}, 32'(irq_any), 32'(|ref_irq()));
        chk({tag, " rdata"}, rdata, ref_rd(a));
    endtask

    task automatic idle(input int k, input logic [2:0] a, input string tag);
        for (int i = 0; i < k; i++) cyc(1'b0, a, 32'd0, tag);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R10: reset values
        cyc(0, 3'd0, 0, "R10 sense");
        cyc(0, 3'd1, 0, "R10 prio");
        cyc(0, 3'd2, 0, "R10 pend");
        cyc(0, 3'd5, 0, "R10 mode");
        chk("R10 irq", 32'(irq), 32'd0);

        // R8/R7/R2: enable all priorities, unmask all, pin0 rising
        cyc(1, 3'd1, 32'hFFFF_FFFF, "R8 prio write");
        cyc(1, 3'd4, 32'h0000_00FF, "R7 unmask");
        cyc(1, 3'd0, 32'h1000_0000, "R2 sense pin0 rising");
        cyc(0, 3'd0, 0, "R2 sense readback");
        chk("R2 sense field", rdata, 32'h1000_0000);

        // R1: latency from pin change to request
        @(negedge clk); pins = 8'h01;
        cyc(0, 3'd2, 0, "R1 edge+1");
        cyc(0, 3'd2, 0, "R1 edge+2");
        chk("R1 not yet", 32'(irq[0]), 32'd0);
        cyc(0, 3'd2, 0, "R1 edge+3");
        chk("R1 request", 32'(irq[0]), 32'd1);
        chk("R5 pend layout", rdata, 32'h0000_0080);

        // R5: ones keep, zeros clear
        cyc(1, 3'd2, 32'h0000_00FF, "R5 keep");
        cyc(1, 3'd2, 32'h0000_007F, "R5 clear");
        cyc(0, 3'd2, 0, "R5 cleared");
        chk("R5 pend zero", rdata, 32'd0);
        chk("R5 irq off", 32'(irq_any), 32'd0);

        // R4: pin1 high level, clear loses to set
        cyc(1, 3'd0, 32'h1300_0000, "R3 pin1 high level");
        @(negedge clk); pins = 8'h03;
        idle(3, 3'd2, "R4 level");
        cyc(1, 3'd2, 32'd0, "R4 clear vs set");
        cyc(1, 3'd2, 32'd0, "R4 clear vs set 2");
        chk("R4 set wins", rdata, 32'h0000_0040);

        // R6 / R7 on pin1
        cyc(1, 3'd3, 32'h0000_0040, "R6 mask pin1");
        cyc(0, 3'd3, 0, "R6 masked");
        chk("R6 irq masked", 32'(irq[1]), 32'd0);
        chk("R6 reads zero", rdata, 32'd0);
        cyc(1, 3'd3, 32'h0000_0000, "R6 zero no effect");
        cyc(1, 3'd4, 32'h0000_0000, "R7 zero no effect");
        cyc(0, 3'd4, 0, "R7 still masked");
        chk("R7 zero ignored", 32'(irq[1]), 32'd0);
        cyc(1, 3'd4, 32'h0000_0040, "R7 unmask pin1");
        cyc(0, 3'd2, 0, "R7 unmasked");
        chk("R7 irq back", 32'(irq[1]), 32'd1);

        // R8: zero priority field blocks pin1
        cyc(1, 3'd1, 32'hF0FF_FFFF, "R8 prio pin1 zero");
        cyc(0, 3'd1, 0, "R8 blocked");
        chk("R8 prio gate", 32'(irq[1]), 32'd0);

        // R9: mode bit only
        cyc(1, 3'd5, 32'hFFFF_FFFF, "R9 mode write");
        cyc(0, 3'd5, 0, "R9 mode read");
        chk("R9 mode bit", rdata, 32'h0080_0000);
        cyc(0, 3'd7, 0, "R9 unused addr");

        // R3: invalid code on pin2, both edges on pin3
        cyc(1, 3'd0, 32'h0054_0000, "R3 codes");
        cyc(1, 3'd2, 32'd0, "R3 clear");
        @(negedge clk); pins = 8'h04;
        idle(4, 3'd2, "R3 invalid rise");
        @(negedge clk); pins = 8'h08;
        idle(4, 3'd2, "R3 invalid fall both rise");
        chk("R3 pend pins2/3", rdata & 32'h30, 32'h10);
        cyc(1, 3'd2, 32'd0, "R3 clear");
        @(negedge clk); pins = 8'h00;
        idle(4, 3'd2, "R3 both fall");
        chk("R3 both edges", rdata & 32'h10, 32'h10);

        // Constrained random mix
        for (int i = 0; i < 4000; i++) begin
            logic        we;
            logic [2:0]  a;
            logic [31:0] d;
            if ($urandom_range(0, 3) == 0) pins = pins ^ N'($urandom_range(0, 255));
            we = ($urandom_range(0, 3) == 0);
            a  = 3'($urandom_range(0, 7));
            d  = $urandom;
            if (a == 3'd2 && $urandom_range(0, 1) == 1) d = 32'd0;
            if (a == 3'd0) for (int n = 0; n < 8; n++) d[28-4*n +: 4] = 4'($urandom_range(0, 5));
            cyc(we, a, d, "R3 R5 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule